// File: doc/BRIEF.md
# Class-D Amplifier Mode Sequencer

This block sets the start-up order of a two-channel switching audio amplifier. A two-bit request selects standby, mute or operating. A one-cycle tick arrives once per millisecond. A status input reports whether either output terminal is shorted to a supply rail. The block drives an enable for the power-stage switching, an enable for audio modulation, a carrier phase reference and a state code. While switching is on and audio is off, the modulator holds its carrier at 50% duty.

When standby is left, the outputs are first checked for a rail short, with the power stages still off. Start-up waits for as long as a short is present. Once the check passes, the block counts a switching delay and then turns on the power stage. Audio is allowed only when operating is requested and a minimum dwell since the check has passed. A direct request from standby to operating uses the same path, so audio follows switching by the second delay. A standby request stops everything on the next clock and clears the timers.

Top module: `clsd_mode_seq`

## Requirements
- R1: During and just after reset, sw_en, aud_en and car_ref are 0 and seq_state is 0 (standby).
- R2: mode_req decodes as 00 standby, 01 mute, 10 operating, 11 standby. A request of 11 held in standby keeps seq_state at 0.
- R3: When a mute or operating request arrives in standby, seq_state becomes 1 (short check) on the next clock. It stays at 1, with sw_en at 0, for as long as rail_short is 1.
- R4: On the clock after the check sees rail_short at 0, seq_state becomes 2 (delay). sw_en rises on the clock edge of the SW_TICKS-th tick counted from then. At that point seq_state is 3 (muted, switching).
- R5: While seq_state is 3, sw_en is 1 and aud_en is 0. After the check has passed, rail_short has no effect.
- R6: aud_en is 0 until SW_TICKS+AUD_TICKS ticks have passed since the check passed. If operating is already requested, aud_en and seq_state 4 appear one clock after that tick.
- R7: With a direct standby-to-operating request, aud_en rises one clock after the AUD_TICKS-th tick that follows the rise of sw_en, whatever the spacing of the ticks.
- R8: Once the dwell has elapsed, a mute request clears aud_en on the next clock and keeps sw_en at 1. An operating request sets aud_en again on the next clock.
- R9: A standby request clears sw_en and aud_en, and sets seq_state to 0, on the next clock from any state. Its timers restart, so a later start-up again needs the full SW_TICKS ticks.
- R10: car_ref is 0 while sw_en is 0. Counting cycles i from the first cycle with sw_en at 1, car_ref is 1 exactly when (i mod CAR_PER) lies in [CAR_PER/4, 3*CAR_PER/4). The first pulse therefore opens with a quarter-period low phase.
- R11: Ticks have no effect during standby or the short check. Only ticks after the check has passed are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond pulse |
| mode_req | input | 2 | Requested mode (00 standby, 01 mute, 10 operating, 11 standby) |
| rail_short | input | 1 | 1 while an output terminal is shorted to a supply rail |
| sw_en | output | 1 | Power-stage switching enable |
| aud_en | output | 1 | Audio modulation enable (carrier at 50% duty when low) |
| car_ref | output | 1 | Carrier phase reference, aligned to the start of switching |
| seq_state | output | 3 | 0 standby, 1 short check, 2 delay, 3 muted switching, 4 audio |

## Verification
The assertions assume tick_ms is high for one clock at a time and that mode_req and rail_short change only between clock edges. They also assume the short status is meaningful only during the check state. The stimulus changes inputs just after a rising edge and pulses the tick for single cycles. It sweeps the idle gap between ticks from zero to two cycles. Shorts appear both during the check and after it, and standby requests arrive partway through the delay.

// File: rtl/clsd_seq_pkg.sv
package clsd_seq_pkg;

   typedef enum logic [1:0] {
      REQ_STBY = 2'd0,
      REQ_MUTE = 2'd1,
      REQ_OPER = 2'd2
   } req_e;

   typedef enum logic [2:0] {
      ST_STBY  = 3'd0,
      ST_CHECK = 3'd1,
      ST_WAIT  = 3'd2,
      ST_MUTE  = 3'd3,
      ST_PLAY  = 3'd4
   } seq_st_e;

   function automatic req_e decode_req(input logic [1:0] code);
      case (code)
         2'b01:   return REQ_MUTE;
         2'b10:   return REQ_OPER;
         default: return REQ_STBY;
      endcase
   endfunction

endpackage

// File: rtl/clsd_seq_decode.sv
module clsd_seq_decode
   import clsd_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] code,
   output req_e       req
);

   assign req = decode_req(code);

   // R2
   reserved_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b11) |-> (req == REQ_STBY));

endmodule

// File: rtl/clsd_seq_timer.sv
module clsd_seq_timer #(
   parameter int LIMIT = 150,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          tick,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("clsd_seq_timer: LIMIT must be at least 2");
      end
      if ((1 << CW) <= LIMIT) begin : g_bad_width
         $error("clsd_seq_timer: CW too narrow for LIMIT");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (run && tick && (cnt != LIM_V)) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM_V);

   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/clsd_seq_carrier.sv
module clsd_seq_carrier #(
   parameter int CAR_PER = 8,
   parameter bit CAR_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic car
);

   localparam int PW = (CAR_PER > 2) ? $clog2(CAR_PER) : 1;
   localparam int Q  = CAR_PER / 4;
   localparam logic [PW-1:0] LAST_V = PW'(CAR_PER - 1);
   localparam logic [PW-1:0] Q_V    = PW'(Q);
   localparam logic [PW-1:0] Q3_V   = PW'(3 * Q);

   generate
      if ((CAR_PER < 4) || ((CAR_PER % 4) != 0)) begin : g_bad_per
         $error("clsd_seq_carrier: CAR_PER must be a multiple of 4");
      end

      if (CAR_EN) begin : g_car
         logic [PW-1:0] ph;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph <= '0;
            end else if (!en) begin
               ph <= '0;
            end else if (ph == LAST_V) begin
               ph <= '0;
            end else begin
               ph <= ph + 1'b1;
            end
         end

         assign car = en && (ph >= Q_V) && (ph < Q3_V);

         // R10
         first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en) |-> !car);
      end else begin : g_no_car
         assign car = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/clsd_mode_seq.sv
module clsd_mode_seq
   import clsd_seq_pkg::*;
#(
   parameter int SW_TICKS  = 100,
   parameter int AUD_TICKS = 50,
   parameter int CAR_PER   = 8,
   parameter bit CAR_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic [1:0] mode_req,
   input  logic       rail_short,
   output logic       sw_en,
   output logic       aud_en,
   output logic       car_ref,
   output logic [2:0] seq_state
);

   localparam int TOTAL = SW_TICKS + AUD_TICKS;
   localparam int CW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] SW_LAST_V = CW'(SW_TICKS - 1);
   localparam logic [CW-1:0] TOTAL_V   = CW'(TOTAL);

   generate
      if (SW_TICKS < 1) begin : g_bad_sw
         $error("clsd_mode_seq: SW_TICKS must be at least 1");
      end
      if (AUD_TICKS < 1) begin : g_bad_aud
         $error("clsd_mode_seq: AUD_TICKS must be at least 1");
      end
   endgenerate

   req_e          req;
   seq_st_e       st_q, st_d;
   logic [CW-1:0] cnt;
   logic          tmr_clr, tmr_run, dwell_done, sw_hit;

   clsd_seq_decode i_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (mode_req),
      .req   (req)
   );

   assign tmr_clr = (st_q == ST_STBY) || (st_q == ST_CHECK);
   assign tmr_run = (st_q == ST_WAIT) || (st_q == ST_MUTE) || (st_q == ST_PLAY);

   clsd_seq_timer #(
      .LIMIT (TOTAL),
      .CW    (CW)
   ) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .run   (tmr_run),
      .tick  (tick_ms),
      .cnt   (cnt)
   );

   assign sw_hit     = tick_ms && (cnt == SW_LAST_V);
   assign dwell_done = (cnt == TOTAL_V);

   always_comb begin
      st_d = st_q;
      if (req == REQ_STBY) begin
         st_d = ST_STBY;
      end else begin
         case (st_q)
            ST_STBY:  st_d = ST_CHECK;
            ST_CHECK: if (!rail_short) st_d = ST_WAIT;
            ST_WAIT:  if (sw_hit) st_d = ST_MUTE;
            ST_MUTE:  if ((req == REQ_OPER) && dwell_done) st_d = ST_PLAY;
            ST_PLAY:  if (req == REQ_MUTE) st_d = ST_MUTE;
            default:  st_d = ST_STBY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_STBY;
      end else begin
         st_q <= st_d;
      end
   end

   assign sw_en     = (st_q == ST_MUTE) || (st_q == ST_PLAY);
   assign aud_en    = (st_q == ST_PLAY);
   assign seq_state = st_q;

   clsd_seq_carrier #(
      .CAR_PER (CAR_PER),
      .CAR_EN  (CAR_EN)
   ) i_car (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sw_en),
      .car   (car_ref)
   );

   // R3
   short_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_CHECK) && rail_short && (req != REQ_STBY)) |=> (st_q == ST_CHECK));

   // R9
   stby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == REQ_STBY) |=> (!sw_en && !aud_en));

   // R6
   aud_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aud_en) |-> $past(req == REQ_OPER));

   // R4
   sw_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en) |-> $past(tick_ms));

endmodule

// File: tb/test_clsd_mode_seq.sv
module test_clsd_mode_seq;

   localparam int SW  = 6;
   localparam int AUD = 3;
   localparam int PER = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic [1:0] mode_req = 2'b00;
   logic       rail_short = 1'b0;
   logic       sw_en, aud_en, car_ref;
   logic [2:0] seq_state;

   int nchk = 0;
   int nfail = 0;
   int ci = 0;

   always #5 clk = ~clk;

   clsd_mode_seq #(
      .SW_TICKS  (SW),
      .AUD_TICKS (AUD),
      .CAR_PER   (PER),
      .CAR_EN    (1'b1)
   ) i_clsd_mode_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_ms    (tick_ms),
      .mode_req   (mode_req),
      .rail_short (rail_short),
      .sw_en      (sw_en),
      .aud_en     (aud_en),
      .car_ref    (car_ref),
      .seq_state  (seq_state)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_car(input int i);
      int p;
      p = i % PER;
      return ((p >= PER / 4) && (p < 3 * PER / 4)) ? 1 : 0;
   endfunction

   task automatic step(input logic t);
      tick_ms = t;
      @(posedge clk);
      #1;
      tick_ms = 1'b0;
   endtask

   task automatic step_car(input logic t);
      step(t);
      ci++;
      chk("R10 carrier phase", int'(car_ref), exp_car(ci));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset sw_en", int'(sw_en), 0);
      chk("R1 reset aud_en", int'(aud_en), 0);
      chk("R1 reset car_ref", int'(car_ref), 0);
      chk("R1 reset state", int'(seq_state), 0);
      rst_n = 1'b1;
      step(1'b0);
      chk("R1 after reset state", int'(seq_state), 0);

      // R2: code 11 stays in standby
      mode_req = 2'b11;
      for (int k = 0; k < 3; k++) begin
         step(1'b1);
         chk("R2 code 11 standby", int'(seq_state), 0);
      end

      // R3 / R11: stall during short, ticks ignored
      mode_req = 2'b01;
      rail_short = 1'b1;
      step(1'b0);
      chk("R3 enter check", int'(seq_state), 1);
      for (int k = 0; k < 4; k++) begin
         step(1'b1);
         chk("R3 stalled state", int'(seq_state), 1);
         chk("R3 no switching", int'(sw_en), 0);
      end
      rail_short = 1'b0;
      step(1'b0);
      chk("R4 delay state", int'(seq_state), 2);
      chk("R10 carrier idle", int'(car_ref), 0);
      for (int k = 1; k <= SW; k++) begin
         step(1'b1);
         chk("R11 R4 sw_en vs ticks", int'(sw_en), (k == SW) ? 1 : 0);
      end
      chk("R5 muted state", int'(seq_state), 3);
      chk("R5 no audio", int'(aud_en), 0);
      ci = 0;
      chk("R10 first low", int'(car_ref), exp_car(0));

      // early operating request; short after check ignored
      mode_req = 2'b10;
      rail_short = 1'b1;
      for (int k = SW + 1; k <= SW + AUD; k++) begin
         step_car(1'b1);
         chk("R6 audio held", int'(aud_en), 0);
         chk("R5 short ignored", int'(sw_en), 1);
      end
      step_car(1'b0);
      chk("R6 audio after dwell", int'(aud_en), 1);
      chk("R6 play state", int'(seq_state), 4);
      for (int k = 0; k < 2 * PER; k++) step_car(1'b0);

      // R8
      mode_req = 2'b01;
      step(1'b0);
      chk("R8 mute drops audio", int'(aud_en), 0);
      chk("R8 mute keeps sw", int'(sw_en), 1);
      mode_req = 2'b10;
      step(1'b0);
      chk("R8 audio resumes", int'(aud_en), 1);

      // R9 / R2: code 11 is standby
      mode_req = 2'b11;
      step(1'b0);
      chk("R9 standby sw", int'(sw_en), 0);
      chk("R9 standby aud", int'(aud_en), 0);
      chk("R2 code 11 state", int'(seq_state), 0);
      chk("R10 car off", int'(car_ref), 0);
      rail_short = 1'b0;

      // R7: direct standby -> operating, swept tick gaps
      for (int gap = 0; gap < 3; gap++) begin
         mode_req = 2'b00;
         step(1'b0);
         mode_req = 2'b10;
         step(1'b0);
         chk("R3 direct check", int'(seq_state), 1);
         step(1'b0);
         chk("R4 direct delay", int'(seq_state), 2);
         for (int k = 1; k <= SW; k++) begin
            for (int g = 0; g < gap; g++) begin
               step(1'b0);
               chk("R4 idle gap", int'(sw_en), 0);
            end
            step(1'b1);
            chk("R4 direct sw_en", int'(sw_en), (k == SW) ? 1 : 0);
         end
         for (int k = 1; k <= AUD; k++) begin
            for (int g = 0; g < gap; g++) step(1'b0);
            step(1'b1);
            chk("R7 audio held", int'(aud_en), 0);
         end
         step(1'b0);
         chk("R7 audio on", int'(aud_en), 1);
      end

      // R9: timers restart
      mode_req = 2'b00;
      step(1'b0);
      mode_req = 2'b01;
      step(1'b0);
      step(1'b0);
      for (int k = 1; k < SW; k++) step(1'b1);
      mode_req = 2'b00;
      step(1'b0);
      chk("R9 abort state", int'(seq_state), 0);
      mode_req = 2'b01;
      step(1'b0);
      step(1'b0);
      for (int k = 1; k < SW; k++) step(1'b1);
      chk("R9 full delay again", int'(sw_en), 0);
      step(1'b1);
      chk("R9 switching after full delay", int'(sw_en), 1);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule